// File: doc/BRIEF.md
# Key-Protected Mode Transition Controller

This block governs which operating mode a chip is in and moves a set of modelled resource enables (clock gates, peripheral enables and the like) from one mode's configuration to the next. Software asks for a mode change by writing the control word twice. The first write carries an unlock key and the target mode. The second carries the bitwise complement of that key and the same target. Any other pairing is discarded. Each mode has its own configuration word in a register bank. That word is captured when a request is accepted and is then applied to the resource vector.

While the resource vector differs from the captured word, a transition flag stays high. Each differing resource bit settles after a programmable number of cycles. When every bit matches, the flag drops and the current-mode field shows the new mode in the same cycle. A request for the mode already active is a valid request. It is how edits to the active mode's configuration word take effect, because those edits otherwise wait for the next entry into that mode.

Top module: `mode_xfer_ctl`

## Requirements
- R1: After reset the current mode is DRUN (code 3), the transition flag is 0 and the resource vector equals the RST_CFG parameter.
- R2: Address 0 is the control word, with target mode in bits [31:28] and key in bits [15:0]. A write with key 0x5AF0 and a known target, followed by a control write with key 0xA50F and the same target, sets the transition flag in the cycle after the second write.
- R3: If the control write that follows an unlock write has a key other than 0xA50F, or a different target, no transition starts. A later lone 0xA50F write does not start one either; a fresh 0x5AF0 write is needed.
- R4: The known mode codes are RESET=0, TEST=1, SAFE=2, DRUN=3, RUN0..RUN3=4..7, HALT=8, STOP=10 and STANDBY=13. An unlock write whose target is any other code is ignored.
- R5: The resource vector changes only while the transition flag is set. Each bit that differs from the captured configuration flips after SETTLE cycles of mismatch, so a transition that changes any bit keeps the flag high for SETTLE+1 cycles.
- R6: The flag clears in the cycle after the resource vector equals the captured configuration, and the current mode takes the requested code in that same cycle. A request whose configuration already matches keeps the flag high for exactly one cycle. A request for the active mode is valid.
- R7: Control writes made while the transition flag is set are ignored and leave no partial unlock behind.
- R8: Address 16+m writes mode m's configuration word from bits [RES_W-1:0]. Writing the active mode's word does not change the resource vector until that mode is requested again.
- R9: The configuration is captured at acceptance. A write to the target's word after acceptance does not alter the transition in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0 control, 16+m mode m configuration |
| wr_data | input | 32 | Write data |
| cur_mode_o | output | 4 | Current mode code |
| trans_o | output | 1 | Transition in progress |
| res_o | output | RES_W | Modelled resource enables |

## Verification
The hardest situation to reach is a control write that arrives while a transition is already running. The flag only lasts SETTLE+1 cycles, so the stimulus sends a complete key pair immediately after an accepted request whose configuration differs in several bits. The pair lands inside that window, and the bench then confirms that no second transition follows. A similar window is used for the capture rule: the target's configuration word is rewritten in the first cycle after acceptance, and the bench checks that the resource vector still settles on the old word.

// File: rtl/mxc_pkg.sv
package mxc_pkg;
   localparam int MODE_W = 4;
   typedef logic [MODE_W-1:0] mode_t;

   localparam mode_t MODE_RESET   = 4'd0;
   localparam mode_t MODE_TEST    = 4'd1;
   localparam mode_t MODE_SAFE    = 4'd2;
   localparam mode_t MODE_DRUN    = 4'd3;
   localparam mode_t MODE_RUN3    = 4'd7;
   localparam mode_t MODE_HALT    = 4'd8;
   localparam mode_t MODE_STOP    = 4'd10;
   localparam mode_t MODE_STANDBY = 4'd13;

   localparam logic [15:0] KEY_FWD = 16'h5AF0;
   localparam logic [15:0] KEY_INV = 16'hA50F;

   function automatic logic mode_known(input mode_t m);
      return (m <= MODE_RUN3) || (m == MODE_HALT) ||
             (m == MODE_STOP) || (m == MODE_STANDBY);
   endfunction
endpackage

// File: rtl/mxc_key_seq.sv
module mxc_key_seq
   import mxc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctrl_wr,
   input  logic [15:0] key,
   input  mode_t       tgt,
   input  logic        busy,
   output logic        accept,
   output mode_t       acc_mode
);
   typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_t;

   seq_t  state_q;
   mode_t held_q;
   logic  wr_ok;

   assign wr_ok    = ctrl_wr && !busy;
   assign accept   = wr_ok && (state_q == SEQ_ARMED) && (key == KEY_INV) && (tgt == held_q);
   assign acc_mode = held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         held_q  <= MODE_DRUN;
      end else if (wr_ok) begin
         if (state_q == SEQ_IDLE) begin
            if (key == KEY_FWD && mode_known(tgt)) begin
               state_q <= SEQ_ARMED;
               held_q  <= tgt;
            end
         end else begin
            state_q <= SEQ_IDLE;
         end
      end
   end

   // R3: any control write in the armed state returns to idle
   p_abort_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !busy && state_q == SEQ_ARMED) |=> (state_q == SEQ_IDLE));
   // R4: unknown target codes never arm the sequence
   p_unknown_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && state_q == SEQ_IDLE && !mode_known(tgt)) |=> (state_q == SEQ_IDLE));
   // R7: writes during a transition do not disturb the sequence
   p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (state_q == $past(state_q)));
endmodule

// File: rtl/mxc_cfg_bank.sv
module mxc_cfg_bank
   import mxc_pkg::*;
#(
   parameter int               RES_W   = 8,
   parameter int               NMODES  = 16,
   parameter logic [RES_W-1:0] RST_CFG = '1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  mode_t            wr_sel,
   input  logic [RES_W-1:0] wr_val,
   input  mode_t            rd_sel,
   output logic [RES_W-1:0] rd_val
);
   logic [RES_W-1:0] word_q [NMODES];

   for (genvar m = 0; m < NMODES; m++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               word_q[m] <= RST_CFG;
         else if (wr_en && wr_sel == mode_t'(m))   word_q[m] <= wr_val;
      end
   end

   assign rd_val = word_q[rd_sel];

   initial begin : p_depth_chk
      assert (NMODES == (1 << MODE_W)) else $error("NMODES must cover the mode code space");
   end
endmodule

// File: rtl/mxc_res_step.sv
module mxc_res_step #(
   parameter int               RES_W      = 8,
   parameter int               SETTLE     = 4,
   parameter bit               SHARED_CNT = 1'b0,
   parameter logic [RES_W-1:0] RST_CFG    = '1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic [RES_W-1:0] tgt_cfg,
   output logic [RES_W-1:0] res_o
);
   localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

   if (SHARED_CNT) begin : g_shared
      logic [CNT_W-1:0] cnt_q;
      logic [RES_W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            res_q <= RST_CFG;
         end else if (busy && res_q != tgt_cfg) begin
            if (cnt_q == CNT_LAST) begin
               res_q <= tgt_cfg;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
      assign res_o = res_q;
   end else begin : g_per_bit
      for (genvar i = 0; i < RES_W; i++) begin : g_bit
         logic [CNT_W-1:0] cnt_q;
         logic             bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               bit_q <= RST_CFG[i];
            end else if (busy && bit_q != tgt_cfg[i]) begin
               if (cnt_q == CNT_LAST) begin
                  bit_q <= ~bit_q;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end
         assign res_o[i] = bit_q;
      end
   end

   initial begin : p_param_chk
      assert (SETTLE >= 1) else $error("SETTLE must be at least 1");
      assert (RES_W >= 1 && RES_W <= 32) else $error("RES_W must be 1..32");
   end

   // R5: resources move only during a transition
   p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(res_o));
   // R5: once matched, resources hold
   p_settled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && res_o == tgt_cfg) |=> $stable(res_o));
endmodule

// File: rtl/mode_xfer_ctl.sv
module mode_xfer_ctl
   import mxc_pkg::*;
#(
   parameter int               RES_W      = 8,
   parameter int               SETTLE     = 4,
   parameter bit               SHARED_CNT = 1'b0,
   parameter logic [RES_W-1:0] RST_CFG    = '1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [4:0]       wr_addr,
   input  logic [31:0]      wr_data,
   output logic [3:0]       cur_mode_o,
   output logic             trans_o,
   output logic [RES_W-1:0] res_o
);
   localparam int NMODES = 1 << MODE_W;

   logic             ctrl_wr, cfg_wr, accept;
   mode_t            acc_mode, cur_q, pend_q;
   logic             busy_q;
   logic [RES_W-1:0] tgt_q, rd_val, res;
   logic             unused_wr;

   assign ctrl_wr   = wr_en && (wr_addr == 5'd0);
   assign cfg_wr    = wr_en && wr_addr[4];
   assign unused_wr = ^wr_data;

   mxc_key_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr),
      .key      (wr_data[15:0]),
      .tgt      (wr_data[31:28]),
      .busy     (busy_q),
      .accept   (accept),
      .acc_mode (acc_mode)
   );

   mxc_cfg_bank #(.RES_W(RES_W), .NMODES(NMODES), .RST_CFG(RST_CFG)) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr),
      .wr_sel (wr_addr[3:0]),
      .wr_val (wr_data[RES_W-1:0]),
      .rd_sel (acc_mode),
      .rd_val (rd_val)
   );

   mxc_res_step #(.RES_W(RES_W), .SETTLE(SETTLE), .SHARED_CNT(SHARED_CNT), .RST_CFG(RST_CFG)) i_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy_q),
      .tgt_cfg (tgt_q),
      .res_o   (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= MODE_DRUN;
         pend_q <= MODE_DRUN;
         tgt_q  <= RST_CFG;
      end else if (accept) begin
         busy_q <= 1'b1;
         pend_q <= acc_mode;
         tgt_q  <= rd_val;
      end else if (busy_q && res == tgt_q) begin
         busy_q <= 1'b0;
         cur_q  <= pend_q;
      end
   end

   assign cur_mode_o = cur_q;
   assign trans_o    = busy_q;
   assign res_o      = res;

   // R2: an accepted request raises the flag and records its target
   p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_q && pend_q == $past(acc_mode)));
   // R6: match ends the transition and publishes the mode together
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && res == tgt_q) |=> (!busy_q && cur_q == $past(pend_q)));
   // R6: the mode field moves only when a transition completes
   p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && res == tgt_q) |=> $stable(cur_q));
   // R7: no acceptance while a transition runs
   p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !accept);
   // R9: the captured configuration holds for the whole transition
   p_tgt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(tgt_q));
endmodule

// File: tb/test_mode_xfer_ctl.sv
module test_mode_xfer_ctl;
   localparam int SETTLE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  cur_mode_o;
   logic        trans_o;
   logic [7:0]  res_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] cfg_m [16];
   logic [7:0] res_m;
   logic [3:0] mode_m;

   // {unlock key, unlock target, second key, second target, expected accept}
   localparam logic [40:0] VECS [9] = '{
      {16'h5AF0, 4'd4,  16'hA50F, 4'd4,  1'b1},
      {16'h5AF0, 4'd5,  16'hA50F, 4'd6,  1'b0},
      {16'h5AF0, 4'd5,  16'h1234, 4'd5,  1'b0},
      {16'hA50F, 4'd5,  16'hA50F, 4'd5,  1'b0},
      {16'h5AF0, 4'd9,  16'hA50F, 4'd9,  1'b0},
      {16'h5AF0, 4'd2,  16'hA50F, 4'd2,  1'b1},
      {16'h5AF0, 4'd2,  16'hA50F, 4'd2,  1'b1},
      {16'h5AF0, 4'd13, 16'hA50F, 4'd13, 1'b1},
      {16'h5AF0, 4'd3,  16'hA50F, 4'd3,  1'b1}
   };

   mode_xfer_ctl #(.RES_W(8), .SETTLE(SETTLE)) i_mode_xfer_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .cur_mode_o (cur_mode_o),
      .trans_o    (trans_o),
      .res_o      (res_o)
   );

   always #2 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the sampling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic ctrl(input logic [15:0] k, input logic [3:0] t);
      wr(5'd0, {t, 12'h000, k});
   endtask

   task automatic wait_done(output int d);
      d = 0;
      while (trans_o === 1'b1 && d < 1000) begin
         d++;
         @(negedge clk);
      end
   endtask

   task automatic request(input logic [15:0] k1, input logic [3:0] t1,
                          input logic [15:0] k2, input logic [3:0] t2, input bit ok);
      int d, exp_d;
      ctrl(k1, t1);
      ctrl(k2, t2);
      check(trans_o === ok, ok ? "R2 accept" : "R3/R4 reject", int'(trans_o), int'(ok));
      if (ok) begin
         exp_d = (cfg_m[t2] == res_m) ? 1 : SETTLE + 1;
         wait_done(d);
         check(d == exp_d, "R5/R6 transition length", d, exp_d);
         mode_m = t2;
         res_m  = cfg_m[t2];
      end else begin
         @(negedge clk);
         check(trans_o === 1'b0, "R3 no transition", int'(trans_o), 0);
      end
      check(cur_mode_o === mode_m, "R6 current mode", int'(cur_mode_o), int'(mode_m));
      check(res_o === res_m, "R6 resources", int'(res_o), int'(res_m));
   endtask

   initial begin
      int d;
      for (int m = 0; m < 16; m++) cfg_m[m] = 8'hFF;
      res_m  = 8'hFF;
      mode_m = 4'd3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cur_mode_o === 4'd3, "R1 mode", int'(cur_mode_o), 3);
      check(trans_o === 1'b0, "R1 flag", int'(trans_o), 0);
      check(res_o === 8'hFF, "R1 resources", int'(res_o), 8'hFF);

      // R8 program every configuration word, including the active one
      for (int m = 0; m < 16; m++) begin
         cfg_m[m] = 8'(m * 41 + 19);
         wr(5'(16 + m), {24'h0, cfg_m[m]});
      end
      repeat (3) @(negedge clk);
      check(res_o === res_m, "R8 active word no immediate effect", int'(res_o), int'(res_m));
      check(trans_o === 1'b0, "R8 no transition from config write", int'(trans_o), 0);

      // table walk: R2, R3, R4, R6 (entry 6 is a matching re-entry)
      for (int v = 0; v < 9; v++)
         request(VECS[v][40:25], VECS[v][24:21], VECS[v][20:5], VECS[v][4:1], VECS[v][0]);

      // R7: key pair inside a running transition is dropped
      ctrl(16'h5AF0, 4'd7);
      ctrl(16'hA50F, 4'd7);
      check(trans_o === 1'b1, "R7 first request accepted", int'(trans_o), 1);
      ctrl(16'h5AF0, 4'd6);
      ctrl(16'hA50F, 4'd6);
      wait_done(d);
      mode_m = 4'd7; res_m = cfg_m[7];
      repeat (4) @(negedge clk);
      check(trans_o === 1'b0, "R7 no second transition", int'(trans_o), 0);
      check(cur_mode_o === 4'd7, "R7 mode", int'(cur_mode_o), 7);
      ctrl(16'hA50F, 4'd6);
      @(negedge clk);
      check(trans_o === 1'b0, "R7 no partial unlock left", int'(trans_o), 0);

      // R9: rewrite target word right after acceptance
      ctrl(16'h5AF0, 4'd4);
      ctrl(16'hA50F, 4'd4);
      wr(5'd20, 32'h0000_005A);
      wait_done(d);
      check(res_o === cfg_m[4], "R9 captured word applied", int'(res_o), int'(cfg_m[4]));
      check(cur_mode_o === 4'd4, "R9 mode", int'(cur_mode_o), 4);
      mode_m = 4'd4; res_m = cfg_m[4];
      cfg_m[4] = 8'h5A;

      // R8: new word of the active mode waits, then applies on re-entry
      repeat (3) @(negedge clk);
      check(res_o === res_m, "R8 pending word held", int'(res_o), int'(res_m));
      request(16'h5AF0, 4'd4, 16'hA50F, 4'd4, 1'b1);
      check(res_o === 8'h5A, "R8 re-entry applies word", int'(res_o), 8'h5A);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule